// File: doc/BRIEF.md
# Reloading Down-Counter Tick Timer

A periodic tick source for a processor subsystem. Software writes a reload value, clears the count and turns the timer on. From then on the count falls by one on every tick. When it passes from one to zero, a sticky done flag is raised. On the next tick the count returns to the reload value, so the flag rises again every (reload + 1) ticks. A tick is either every core clock, or only those core clocks on which an external tick-enable input is high.

Software reaches the timer through a plain synchronous port with a byte address, write data, a write strobe, a read strobe and combinational read data. Polling software reads the control word until the flag shows, and that read clears the flag. Interrupt-driven software sets the interrupt-enable bit and receives a level request that stays high for as long as the flag is set.

Top module: `tick_timer`

## Requirements
- R1: After rst_ni is low, the control word, reload value and count all read as zero, and irq_o is low.
- R2: The control word is at offset 0x0, with bit 0 run, bit 1 interrupt enable and bit 2 clock select. It reads back those three bits and the flag in bit 16, and every other bit reads zero. The reload value is at offset 0x4 and keeps the low 24 bits written, so writing all ones reads back 0x00FFFFFF.
- R3: While the run bit is 0, the count holds its value.
- R4: With run = 1, a clock select of 1 makes one tick per clk_i cycle. A clock select of 0 makes one tick only in cycles where ext_tick_i is high.
- R5: A tick that finds the count at zero loads the reload value. A tick that takes the count from 1 to 0 sets the flag, so with a nonzero reload R the flag sets every R + 1 ticks.
- R6: The flag stays set until it is cleared. A read strobe at offset 0x0 returns the flag as 1 in the same cycle and clears it at that clock edge.
- R7: irq_o is high exactly while the flag is set and the interrupt-enable bit is 1, and it stays high for as long as both hold.
- R8: Any write to offset 0x8 forces the count to zero and clears the flag, whatever the write data. No flag or request follows from it, even if a tick falls in the same cycle.
- R9: With a reload value of zero, a running count at zero stays at zero and the flag never sets.
- R10: If a control-word read strobe and a 1-to-0 tick fall in the same cycle, the flag ends up set.
- R11: Reading offset 0x8 returns the live count in bits 23:0, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte address, decoded in bits 3:2 |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; a read of the control word clears the flag |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ext_tick_i | input | 1 | Tick enable used when the clock select is 0 |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a control-word read that clears the flag and a 1-to-0 tick that sets it. The second pair is a count-clearing write and a tick. The bench uses the external tick input to step the count to exactly 1. It then raises ext_tick_i in the same cycle as the read strobe or the write strobe. Afterwards it inspects the flag, the count and irq_o without side effects. The flag must survive the read, while the write must leave both the count and the flag at zero.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IE_BIT  = 1;
  localparam int CTRL_SRC_BIT = 2;
  localparam int FLAG_BIT     = 16;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic src;
    logic ie;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              flag_i,
  input  logic [CNT_W-1:0]  count_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cnt_wr_o,
  output logic              flag_rd_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = ADDR_W - 2;

  reg_sel_e          sel;
  logic [IDX_W-1:0]  idx;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic              unused_bits;

  assign idx = addr_i[ADDR_W-1:2];
  assign unused_bits = ^{wdata_i[DATA_W-1:CNT_W], addr_i[1:0]};

  always_comb begin
    sel = SEL_NONE;
    if (idx == IDX_W'(0))      sel = SEL_CTRL;
    else if (idx == IDX_W'(1)) sel = SEL_RELOAD;
    else if (idx == IDX_W'(2)) sel = SEL_COUNT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_i) begin
      if (sel == SEL_CTRL)
        ctrl_q <= '{src: wdata_i[CTRL_SRC_BIT], ie: wdata_i[CTRL_IE_BIT],
                    run: wdata_i[CTRL_RUN_BIT]};
      if (sel == SEL_RELOAD) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CTRL: begin
        rdata_o[CTRL_RUN_BIT] = ctrl_q.run;
        rdata_o[CTRL_IE_BIT]  = ctrl_q.ie;
        rdata_o[CTRL_SRC_BIT] = ctrl_q.src;
        rdata_o[FLAG_BIT]     = flag_i;
      end
      SEL_RELOAD: rdata_o[CNT_W-1:0] = reload_q;
      SEL_COUNT:  rdata_o[CNT_W-1:0] = count_i;
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign reload_o  = reload_q;
  assign cnt_wr_o  = wr_i && (sel == SEL_COUNT);
  assign flag_rd_o = rd_i && (sel == SEL_CTRL);

  assert_ctrl_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && sel == SEL_CTRL |=> ctrl_o.run == $past(wdata_i[CTRL_RUN_BIT]));
  assert_reload_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(reload_o));
endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             src_i,
  input  logic             ext_tick_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_evt_o
);
  logic [CNT_W-1:0] count_q;
  logic             tick;

  assign tick = run_i && (src_i || ext_tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                count_q <= '0;
    else if (clear_i)           count_q <= '0;
    else if (tick) begin
      if (count_q == '0)        count_q <= reload_i;
      else                      count_q <= count_q - CNT_W'(1);
    end
  end

  // a zero reload means the timer is parked: no event even on a stray 1->0
  assign zero_evt_o = tick && !clear_i && (count_q == CNT_W'(1)) && (reload_i != '0);
  assign count_o    = count_q;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !clear_i |=> $stable(count_q));
  assert_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !clear_i && count_q != '0 |=> count_q == $past(count_q) - CNT_W'(1));
  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !clear_i && count_q == '0 |=> count_q == $past(reload_i));
  assert_park_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i == '0 && count_q == '0 |=> count_q == '0);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> !zero_evt_o);
endmodule

// File: rtl/tick_timer_flag.sv
module tick_timer_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_clr_i,
  input  logic wr_clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // set beats a read-clear so an event in the read cycle is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (wr_clr_i) flag_q <= 1'b0;
    else if (set_i)    flag_q <= 1'b1;
    else if (rd_clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_i;

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !wr_clr_i |=> flag_q);
  assert_wr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> !flag_q);
  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !rd_clr_i && !wr_clr_i |=> flag_q);
  assert_rd_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i && !set_i |=> !flag_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ext_tick_i,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             cnt_wr;
  logic             flag_rd;
  logic             zero_evt;
  logic             flag;

  tick_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .flag_i(flag), .count_i(count),
    .ctrl_o(ctrl), .reload_o(reload), .cnt_wr_o(cnt_wr),
    .flag_rd_o(flag_rd), .rdata_o(rdata_o)
  );

  tick_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl.run), .src_i(ctrl.src),
    .ext_tick_i(ext_tick_i), .clear_i(cnt_wr), .reload_i(reload),
    .count_o(count), .zero_evt_o(zero_evt)
  );

  tick_timer_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(zero_evt), .rd_clr_i(flag_rd),
    .wr_clr_i(cnt_wr), .ie_i(ctrl.ie), .flag_o(flag), .irq_o(irq_o)
  );

  assert_wr_no_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> !irq_o);
  assert_irq_needs_ie_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.ie |-> !irq_o);
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam logic [3:0] A_CTRL = 4'h0, A_RELOAD = 4'h4, A_COUNT = 4'h8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0, ext_tick_i = 1'b0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] q;

  tick_timer uut (.clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .ext_tick_i(ext_tick_i), .irq_o(irq_o));

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; holds the strobes over exactly one rising edge
  task automatic op(input logic wr, input logic rd, input logic [3:0] a,
                    input logic [31:0] d, input logic tk, output logic [31:0] r);
    addr_i = a; wdata_i = d; wr_i = wr; rd_i = rd; ext_tick_i = tk;
    #1 r = rdata_o;
    @(negedge clk_i);
    wr_i = 0; rd_i = 0; ext_tick_i = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] r;
    op(1'b1, 1'b0, a, d, 1'b0, r);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] r);
    op(1'b0, 1'b1, a, '0, 1'b0, r);
  endtask

  task automatic pulse(input int n);
    logic [31:0] r;
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, A_CTRL, '0, 1'b1, r);
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] r);
    addr_i = a;
    #1 r = rdata_o;
  endtask

  task automatic t_reset;
    peek(A_CTRL, q);   check("R1 ctrl", q, 32'h0);
    peek(A_RELOAD, q); check("R1 reload", q, 32'h0);
    peek(A_COUNT, q);  check("R1 count", q, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_core_clock;
    wr(A_RELOAD, 32'd5);
    wr(A_COUNT, 32'd0);
    wr(A_CTRL, 32'h5);
    repeat (3) @(negedge clk_i);
    rd(A_COUNT, q);    check("R11 R4 live count after 3 ticks", q, 32'd3);
    repeat (2) @(negedge clk_i);
    rd(A_CTRL, q);     check("R5 flag after 6 ticks", q, 32'h0001_0005);
    peek(A_CTRL, q);   check("R6 flag cleared by read", q, 32'h5);
    peek(A_COUNT, q);  check("R5 reload on tick at zero", q, 32'd5);
    repeat (4) @(negedge clk_i);
    peek(A_CTRL, q);   check("R5 no flag before period", q, 32'h5);
    peek(A_COUNT, q);  check("R4 count one", q, 32'd1);
    @(negedge clk_i);
    peek(A_CTRL, q);   check("R5 flag period reload+1", q, 32'h0001_0005);
    wr(A_CTRL, 32'h0);
    repeat (3) @(negedge clk_i);
    peek(A_COUNT, q);  check("R3 count held while stopped", q, 32'd5);
    peek(A_CTRL, q);   check("R6 flag sticky", q, 32'h0001_0000);
    wr(A_COUNT, 32'hABC);
    peek(A_COUNT, q);  check("R8 write clears count", q, 32'd0);
    peek(A_CTRL, q);   check("R8 write clears flag", q, 32'h0);
  endtask

  task automatic t_ext_tick;
    wr(A_RELOAD, 32'd3);
    wr(A_CTRL, 32'h3);
    repeat (4) @(negedge clk_i);
    peek(A_COUNT, q);  check("R4 no tick without ext", q, 32'd0);
    pulse(1);
    peek(A_COUNT, q);  check("R4 ext tick loads", q, 32'd3);
    pulse(3);
    peek(A_COUNT, q);  check("R5 count zero", q, 32'd0);
    check("R7 irq on flag", {31'b0, irq_o}, 32'h1);
    repeat (2) @(negedge clk_i);
    check("R7 irq level held", {31'b0, irq_o}, 32'h1);
    wr(A_CTRL, 32'h1);
    check("R7 irq masked", {31'b0, irq_o}, 32'h0);
    peek(A_CTRL, q);   check("R7 flag kept when masked", q, 32'h0001_0001);
    wr(A_CTRL, 32'h3);
    check("R7 irq back", {31'b0, irq_o}, 32'h1);
    rd(A_CTRL, q);     check("R6 read returns flag", q, 32'h0001_0003);
    check("R6 R7 irq drops after read", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_collide;
    pulse(4);
    peek(A_CTRL, q);   check("R5 flag set again", q, 32'h0001_0003);
    pulse(3);
    peek(A_COUNT, q);  check("R4 count at one", q, 32'd1);
    op(1'b0, 1'b1, A_CTRL, '0, 1'b1, q);
    check("R10 read value in collision", q, 32'h0001_0003);
    peek(A_CTRL, q);   check("R10 set wins over read clear", q, 32'h0001_0003);
    check("R10 irq stays", {31'b0, irq_o}, 32'h1);
    rd(A_CTRL, q);
    peek(A_CTRL, q);   check("R6 plain read clears", q, 32'h3);
    pulse(3);
    op(1'b1, 1'b0, A_COUNT, 32'h55, 1'b1, q);
    peek(A_COUNT, q);  check("R8 write beats tick", q, 32'd0);
    peek(A_CTRL, q);   check("R8 no flag from write", q, 32'h3);
    check("R8 no irq from write", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_zero_and_fields;
    wr(A_CTRL, 32'h0);
    wr(A_RELOAD, 32'h0);
    wr(A_COUNT, 32'h0);
    wr(A_CTRL, 32'h5);
    repeat (5) @(negedge clk_i);
    peek(A_COUNT, q);  check("R9 parked at zero", q, 32'd0);
    peek(A_CTRL, q);   check("R9 no flag", q, 32'h5);
    wr(A_CTRL, 32'hFFFF_FFFF);
    peek(A_CTRL, q);   check("R2 ctrl field mask", q, 32'h7);
    wr(A_CTRL, 32'h0);
    wr(A_RELOAD, 32'hFFFF_FFFF);
    peek(A_RELOAD, q); check("R2 reload width", q, 32'h00FF_FFFF);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_core_clock();
    t_ext_tick();
    t_collide();
    t_zero_and_fields();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule